// File: doc/BRIEF.md
# Event-count qualifying filter

The block sits in front of one event channel of a timer. It selects one of ten external event pulse lines with a 4-bit source field. It counts the pulses that arrive on that line and produces a qualified event only when a programmable number of them has been seen. The qualified event is a single-cycle pulse, and the counter then starts again from zero. When the filter is disabled, each selected pulse goes straight through with one cycle of latency.

The count can restart on a timer reset or roll-over pulse in one of two ways. In the first mode it restarts on every such pulse. In the second mode it restarts only when the period that is ending contained no source event. Software can also clear the count at any time. It does this by writing 1 to a control bit that reads back as 1 for one cycle and is then cleared by hardware. The timer, the register decode and the edge detection of the event lines are outside this block.

Top module: `evq_filter`

## Requirements
- R1: After reset, `qual_o` and `clr_flag_o` are 0, and all configuration inputs are expected at 0: threshold 0, source 0, reset mode 0, filter disabled.
- R2: `src_sel_i` values 0 to 9 select `ev_i[0]` to `ev_i[9]`. Values 10 to 15 select no line, so no pulse ever reaches the output.
- R3: With `en_i`=0, each selected pulse appears on `qual_o` one cycle later. The internal count is held at zero, so it is empty when the filter is enabled.
- R4: With `en_i`=1 and threshold N on `thresh_i`, the (N+1)th counted pulse makes `qual_o` high for exactly one cycle, on the cycle after that pulse. Counting then restarts from zero.
- R5: With `rst_mode_i`=0, every `tmr_rst_i` pulse clears the count. A source pulse in the same cycle is not counted.
- R6: With `rst_mode_i`=1, a `tmr_rst_i` pulse clears the count only if no source pulse arrived since the previous `tmr_rst_i` (or since enable), that same cycle included. Otherwise the count is kept and a pulse in that cycle is counted.
- R7: A cycle with `clr_we_i`=1 and `clr_wdata_i`=1 makes `clr_flag_o` read 1 in the next cycle. In that cycle the count is cleared and a source pulse is not counted. The flag then returns to 0 unless it is written again. Writing 0 changes neither the flag nor the count.
- R8: With threshold 0 and the filter enabled, every counted source pulse is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_i | input | 10 | External event pulses, one cycle per event |
| tmr_rst_i | input | 1 | Timer reset / roll-over pulse |
| thresh_i | input | 6 | Threshold N; qualification on N+1 pulses |
| src_sel_i | input | 4 | Source select, 0..9 valid |
| rst_mode_i | input | 1 | 0: clear on every period, 1: clear only after an idle period |
| en_i | input | 1 | Filter enable |
| clr_we_i | input | 1 | Write strobe for the count-clear bit |
| clr_wdata_i | input | 1 | Data written to the count-clear bit |
| qual_o | output | 1 | Qualified event pulse |
| clr_flag_o | output | 1 | Read-back of the self-clearing clear bit |

## Verification
The assertions expect each event line and the timer pulse to be synchronous to `clk_i`, already edge-detected, and held at 0 while reset is asserted. The stimulus drives every input on the falling edge. It holds all inputs low during reset and produces events only as one-cycle or level patterns that the counting rule accepts as they are. Configuration changes in the random phase, threshold included, happen at arbitrary cycles. A threshold lowered below the current count therefore takes effect on the next counted pulse.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned EVQ_N_EV  = 10;
  localparam int unsigned EVQ_THR_W = 6;
  localparam int unsigned EVQ_SEL_W = 4;

  typedef enum logic {
    RM_EVERY = 1'b0,
    RM_IDLE  = 1'b1
  } rst_mode_e;
endpackage

// File: rtl/evq_src_mux.sv
module evq_src_mux #(
  parameter int unsigned N_EV  = 10,
  parameter int unsigned SEL_W = 4
) (
  input  logic [N_EV-1:0]  ev_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             src_ev_o
);
  logic [N_EV-1:0] hit;

  // one-hot decode; codes >= N_EV match no line
  for (genvar g = 0; g < N_EV; g++) begin : g_dec
    assign hit[g] = (sel_i == SEL_W'(g)) & ev_i[g];
  end

  assign src_ev_o = |hit;

  always_comb begin
    if (sel_i >= SEL_W'(N_EV)) begin
      assert (!src_ev_o) else $error("p_reserved_quiet_r2");
    end
  end
endmodule

// File: rtl/evq_clr_ctrl.sv
module evq_clr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  output logic clr_o
);
  logic clr_q;

  // set by a write of 1, dropped by hardware after one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= we_i & wdata_i;
  end

  assign clr_o = clr_q;

  p_selfclear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q && !(we_i && wdata_i) |=> !clr_q);
  p_write0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_q && !(we_i && wdata_i) |=> !clr_q);
endmodule

// File: rtl/evq_counter.sv
module evq_counter
  import evq_pkg::*;
#(
  parameter int unsigned THR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_ev_i,
  input  logic             tmr_rst_i,
  input  rst_mode_e        rst_mode_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             clr_i,
  output logic             qual_o
);
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             qual_q, qual_d;
  logic             tmr_clr;
  logic             hit_thr;

  // idle-period test counts an event in the closing cycle as seen
  assign tmr_clr = tmr_rst_i &&
                   ((rst_mode_i == RM_EVERY) || (!seen_q && !src_ev_i));
  assign hit_thr = (cnt_q >= thresh_i);

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    qual_d = 1'b0;
    if (!en_i) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      qual_d = src_ev_i;
    end else begin
      if (clr_i || tmr_clr) begin
        cnt_d = '0;
      end else if (src_ev_i) begin
        if (hit_thr) begin
          cnt_d  = '0;
          qual_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      seen_d = tmr_rst_i ? 1'b0 : (seen_q | src_ev_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      qual_q <= qual_d;
    end
  end

  assign qual_o = qual_q;

  p_dis_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && !seen_q);
  p_qual_needs_ev_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> $past(src_ev_i));
  p_qual_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && src_ev_i && !clr_i && !tmr_rst_i && hit_thr |=> qual_o && (cnt_q == '0));
  p_mode0_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tmr_rst_i && (rst_mode_i == RM_EVERY) |=> (cnt_q == '0) && !qual_o);
  p_mode1_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tmr_rst_i && (rst_mode_i == RM_IDLE) && seen_q && !clr_i && !src_ev_i
    |=> cnt_q == $past(cnt_q));
  p_swclr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && clr_i |=> (cnt_q == '0) && !qual_o);
  p_thr0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (thresh_i == '0) && src_ev_i && !clr_i && !tmr_clr |=> qual_o);
endmodule

// File: rtl/evq_filter.sv
module evq_filter
  import evq_pkg::*;
#(
  parameter int unsigned N_EV  = EVQ_N_EV,
  parameter int unsigned THR_W = EVQ_THR_W,
  parameter int unsigned SEL_W = EVQ_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EV-1:0]  ev_i,
  input  logic             tmr_rst_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             rst_mode_i,
  input  logic             en_i,
  input  logic             clr_we_i,
  input  logic             clr_wdata_i,
  output logic             qual_o,
  output logic             clr_flag_o
);
  logic      src_ev;
  logic      sw_clr;
  rst_mode_e rst_mode;

  assign rst_mode = rst_mode_e'(rst_mode_i);

  evq_src_mux #(.N_EV(N_EV), .SEL_W(SEL_W)) u_mux (
    .ev_i    (ev_i),
    .sel_i   (src_sel_i),
    .src_ev_o(src_ev)
  );

  evq_clr_ctrl u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (clr_we_i),
    .wdata_i(clr_wdata_i),
    .clr_o  (sw_clr)
  );

  evq_counter #(.THR_W(THR_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .src_ev_i  (src_ev),
    .tmr_rst_i (tmr_rst_i),
    .rst_mode_i(rst_mode),
    .thresh_i  (thresh_i),
    .clr_i     (sw_clr),
    .qual_o    (qual_o)
  );

  assign clr_flag_o = sw_clr;

  p_pass_through_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> qual_o == $past(src_ev));
endmodule

// File: tb/tb_evq_filter.sv
module tb_evq_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] ev = '0;
  logic       tmr = 1'b0;
  logic [5:0] thr = '0;
  logic [3:0] sel = '0;
  logic       rstm = 1'b0;
  logic       en = 1'b0;
  logic       cwe = 1'b0;
  logic       cwd = 1'b0;
  logic       qual, cflag;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  string phase = "R1";

  // reference state
  int m_cnt = 0;
  bit m_seen = 0, m_clr = 0, m_q = 0;

  always #2.5 clk = ~clk;

  evq_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .tmr_rst_i(tmr),
    .thresh_i(thr), .src_sel_i(sel), .rst_mode_i(rstm), .en_i(en),
    .clr_we_i(cwe), .clr_wdata_i(cwd), .qual_o(qual), .clr_flag_o(cflag)
  );

  always @(posedge clk) begin
    bit src, tclr;
    if (!rst_n) begin
      m_cnt = 0; m_seen = 0; m_clr = 0; m_q = 0;
    end else begin
      src = (sel < 10) ? ev[sel] : 1'b0;
      if (!en) begin
        m_q = src; m_cnt = 0; m_seen = 0;
      end else begin
        tclr = tmr && (!rstm || (!m_seen && !src));
        m_q = 0;
        if (m_clr || tclr) m_cnt = 0;
        else if (src) begin
          if (m_cnt >= thr) begin m_q = 1; m_cnt = 0; end
          else m_cnt++;
        end
        m_seen = tmr ? 1'b0 : (m_seen | src);
      end
      m_clr = cwe && cwd;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (qual !== m_q || cflag !== m_clr) begin
        n_fail++;
        $display("FAIL %s cycle compare: qual=%0b clr=%0b expected qual=%0b clr=%0b",
                 phase, qual, cflag, m_q, m_clr);
      end
      if (qual === 1'b1) pulses++;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evp(int line);
    ev[line] = 1'b1;
    @(negedge clk);
    ev = '0;
    @(negedge clk);
  endtask

  task automatic tmr_pulse();
    tmr = 1'b1;
    @(negedge clk);
    tmr = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_clear();
    cwe = 1'b1; cwd = 1'b1;
    @(negedge clk);
    cwe = 1'b0; cwd = 1'b0;
    idle(2);
  endtask

  task automatic count_from(output int base);
    idle(2); #1; base = pulses;
  endtask

  task automatic count_since(string tag, int base, int exp);
    idle(2); #1;
    check(tag, pulses - base, exp);
  endtask

  initial begin
    int b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 qual after reset", qual, 0);
    check("R1 clr flag after reset", cflag, 0);

    phase = "R3"; sel = 4'd2;
    count_from(b);
    for (int i = 0; i < 5; i++) evp(2);
    count_since("R3 pass-through", b, 5);

    phase = "R2"; sel = 4'd12;
    count_from(b);
    for (int i = 0; i < 5; i++) begin ev = '1; @(negedge clk); ev = '0; @(negedge clk); end
    count_since("R2 reserved select", b, 0);
    sel = 4'd9;
    count_from(b);
    evp(8); evp(9);
    count_since("R2 select 9 -> line 9", b, 1);

    phase = "R4"; en = 1'b1; thr = 6'd3; sel = 4'd4;
    count_from(b);
    for (int i = 0; i < 3; i++) evp(4);
    count_since("R4 below threshold", b, 0);
    evp(4);
    count_since("R4 at threshold", b, 1);
    count_from(b);
    for (int i = 0; i < 8; i++) evp(4);
    count_since("R4 restart", b, 2);

    phase = "R8"; thr = 6'd0;
    count_from(b);
    for (int i = 0; i < 6; i++) evp(4);
    count_since("R8 threshold zero", b, 6);

    phase = "R5"; thr = 6'd3; rstm = 1'b0; sw_clear();
    count_from(b);
    for (int i = 0; i < 3; i++) evp(4);
    tmr_pulse(); evp(4);
    count_since("R5 mode0 clears", b, 0);
    for (int i = 0; i < 3; i++) evp(4);
    count_since("R5 mode0 recount", b, 1);
    thr = 6'd1; sw_clear();
    count_from(b);
    ev[4] = 1'b1; tmr = 1'b1; @(negedge clk); ev = '0; tmr = 1'b0; @(negedge clk);
    evp(4);
    count_since("R5 coincident event dropped", b, 0);
    evp(4);
    count_since("R5 coincident recount", b, 1);

    phase = "R6"; rstm = 1'b1; thr = 6'd3; sw_clear(); tmr_pulse();
    count_from(b);
    evp(4); evp(4); tmr_pulse(); evp(4); evp(4);
    count_since("R6 busy period keeps count", b, 1);
    count_from(b);
    evp(4); evp(4); tmr_pulse(); tmr_pulse(); evp(4); evp(4);
    count_since("R6 idle period clears", b, 0);
    evp(4); evp(4);
    count_since("R6 recount after idle", b, 1);

    phase = "R7"; thr = 6'd2; rstm = 1'b0; sw_clear();
    cwe = 1'b1; cwd = 1'b1; @(negedge clk); cwe = 1'b0; cwd = 1'b0; #1;
    check("R7 flag set", cflag, 1);
    @(negedge clk); #1;
    check("R7 flag self-clears", cflag, 0);
    count_from(b);
    evp(4); evp(4);
    cwe = 1'b1; cwd = 1'b0; @(negedge clk); cwe = 1'b0; #1;
    check("R7 write 0 no flag", cflag, 0);
    evp(4);
    count_since("R7 write 0 keeps count", b, 1);
    count_from(b);
    evp(4); evp(4); sw_clear(); evp(4);
    count_since("R7 clear drops count", b, 0);
    sw_clear();
    count_from(b);
    evp(4); evp(4);
    cwe = 1'b1; cwd = 1'b1; @(negedge clk); cwe = 1'b0; cwd = 1'b0;
    ev[4] = 1'b1; @(negedge clk); ev = '0; @(negedge clk);
    evp(4);
    count_since("R7 event during clear ignored", b, 0);

    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      ev   = 10'($urandom) & 10'($urandom);
      tmr  = ($urandom % 9) == 0;
      cwe  = ($urandom % 23) == 0;
      cwd  = $urandom % 2;
      if (($urandom % 150) == 0) begin
        thr  = 6'($urandom % 6);
        sel  = 4'($urandom % 12);
        rstm = $urandom % 2;
        en   = ($urandom % 5) != 0;
      end
      @(negedge clk);
    end
    ev = '0; tmr = 1'b0; cwe = 1'b0;
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule